// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. It holds a small table with one entry per segment. Each entry stores the physical start address of the segment and the segment's length in bytes. The segment number picks the entry directly. If the offset lies inside the segment, the block returns the start address plus the offset. If it does not, the block raises a trap and returns no address.

A request is presented for one cycle and its response is registered, so the response appears one cycle later. Entries are loaded through a separate write port. That port carries a privilege qualifier. Unprivileged writes are dropped, and a one-cycle error pulse reports them. After reset every entry has a length of zero, so a segment that has never been loaded traps on every access.

Top module: `seg_xlat`

## Requirements
- R1: After reset, rsp_valid, rsp_trap and wr_err are 0, and every entry has length 0, so any request to any segment traps.
- R2: A request whose offset is strictly less than the selected entry's length gives rsp_valid=1, rsp_trap=0 and rsp_paddr = (start + offset) mod 2^PA_W on the cycle after the request.
- R3: A request whose offset is greater than or equal to the selected entry's length gives rsp_valid=1, rsp_trap=1 and rsp_paddr=0 on the cycle after the request.
- R4: The segment number is used directly as the index of the entry, and each of the NUM_SEG entries is checked and offset independently of the others.
- R5: A write with wr_en=1 and wr_priv=1 replaces entry wr_seg with start wr_base and length wr_limit. Requests in later cycles see the new entry. A request in the same cycle as the write sees the old entry.
- R6: A write with wr_en=1 and wr_priv=0 leaves the table unchanged, and wr_err is 1 for exactly the following cycle. In every other cycle wr_err is 0.
- R7: rsp_valid equals req_valid of the previous cycle. Without a request, rsp_valid and rsp_trap are 0.
- R8: The length field is OFF_W+1 bits wide, so a length of 2^OFF_W makes every offset legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| rsp_valid | output | 1 | Registered response is present |
| rsp_paddr | output | PA_W | Translated physical address, 0 on a trap |
| rsp_trap | output | 1 | Offset was outside the segment |
| wr_en | input | 1 | Table write strobe |
| wr_priv | input | 1 | The writer is privileged |
| wr_seg | input | SEG_W | Entry to write |
| wr_base | input | PA_W | New physical start address |
| wr_limit | input | OFF_W+1 | New segment length |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The assertions take two things for granted. First, requests and writes are sampled only at rising edges and are stable around them. Second, reset is held for at least one edge before any traffic. The bench meets both by driving every input on the falling edge and by holding reset for several cycles. Each segment is given a start and a length chosen so that some offsets fall inside the segment, some fall outside, one entry covers the full offset range, and one entry's sum wraps past the top of the physical space. The bench then sweeps every segment against every offset and computes the expected address arithmetically.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_APPLY = 2'd1,
        WR_DENY  = 2'd2
    } wr_kind_e;

    function automatic wr_kind_e classify_write(input logic en, input logic priv);
        if (!en)
            return WR_NONE;
        else if (priv)
            return WR_APPLY;
        else
            return WR_DENY;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 8,
    parameter int SEG_W   = 3,
    parameter int BASE_W  = 16,
    parameter int LIM_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic              rd_hit,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              wr_err
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_SEG-1:0] ent;
        logic                 err;
    } state_t;

    state_t   st_d, st_q;
    wr_kind_e kind;
    entry_t   rd_ent;

    // Next-state logic: privileged writes load one entry, others only flag.
    always_comb begin
        st_d     = st_q;
        kind     = classify_write(wr_en, wr_priv);
        st_d.err = (kind == WR_DENY);
        if (kind == WR_APPLY) begin
            for (int i = 0; i < NUM_SEG; i++) begin
                if (wr_seg == SEG_W'(i)) begin
                    st_d.ent[i].base  = wr_base;
                    st_d.ent[i].limit = wr_limit;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Read side: direct index, indices past NUM_SEG find no entry.
    always_comb begin
        rd_ent = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_seg == SEG_W'(i)) begin
                rd_ent = st_q.ent[i];
                rd_hit = 1'b1;
            end
        end
    end

    assign rd_base  = rd_ent.base;
    assign rd_limit = rd_ent.limit;
    assign wr_err   = st_q.err;

    // R6: a rejected write pulses the error flag on the next cycle
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> wr_err);

    // R6: the flag stays low when no write was rejected
    a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_priv) |=> !wr_err);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry_chk
        // R6: an entry changes only under a privileged write aimed at it
        a_r6_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_priv && (wr_seg == SEG_W'(g))) |=> $stable(st_q.ent[g]));

        // R5: a privileged write lands the written values in the entry
        a_r5_entry_load: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_priv && (wr_seg == SEG_W'(g))) |=>
                (st_q.ent[g].base == $past(wr_base)) && (st_q.ent[g].limit == $past(wr_limit)));
    end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFF_W  = 12,
    parameter int BASE_W = 16,
    parameter int LIM_W  = 13
) (
    input  logic              hit,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [OFF_W-1:0]  off,
    output logic              legal,
    output logic [BASE_W-1:0] paddr
);

    logic [LIM_W-1:0] off_ext;

    always_comb begin
        off_ext = LIM_W'(off);
        legal   = hit && (off_ext < limit);
        paddr   = legal ? (base + BASE_W'(off)) : '0;
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat #(
    parameter int NUM_SEG = 8,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 16,
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int LIM_W  = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_trap,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    output logic             wr_err
);

    typedef struct packed {
        logic            valid;
        logic            trap;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             tbl_hit;
    logic [PA_W-1:0]  tbl_base;
    logic [LIM_W-1:0] tbl_limit;
    logic             chk_legal;
    logic [PA_W-1:0]  chk_paddr;

    seg_table #(
        .NUM_SEG (NUM_SEG),
        .SEG_W   (SEG_W),
        .BASE_W  (PA_W),
        .LIM_W   (LIM_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_priv  (wr_priv),
        .wr_seg   (wr_seg),
        .wr_base  (wr_base),
        .wr_limit (wr_limit),
        .rd_seg   (req_seg),
        .rd_hit   (tbl_hit),
        .rd_base  (tbl_base),
        .rd_limit (tbl_limit),
        .wr_err   (wr_err)
    );

    seg_check #(
        .OFF_W  (OFF_W),
        .BASE_W (PA_W),
        .LIM_W  (LIM_W)
    ) u_check (
        .hit   (tbl_hit),
        .base  (tbl_base),
        .limit (tbl_limit),
        .off   (req_off),
        .legal (chk_legal),
        .paddr (chk_paddr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.trap  = !chk_legal;
            rsp_d.paddr = chk_legal ? chk_paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_paddr = rsp_q.paddr;

    // R7: every request yields a response one cycle later
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no request, no response and no trap
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_trap));

    // R3: a trapped response carries no address
    a_r3_trap_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_paddr == '0));

endmodule

// File: tb/tb_seg_xlat.sv
`timescale 1ns/1ps
module tb_seg_xlat;

    localparam int NUM_SEG = 8;
    localparam int OFF_W   = 12;
    localparam int PA_W    = 16;
    localparam int SEG_W   = 3;
    localparam int LIM_W   = OFF_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_trap;
    logic             wr_en = 1'b0;
    logic             wr_priv = 1'b0;
    logic [SEG_W-1:0] wr_seg = '0;
    logic [PA_W-1:0]  wr_base = '0;
    logic [LIM_W-1:0] wr_limit = '0;
    logic             wr_err;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_base [NUM_SEG];
    int exp_lim  [NUM_SEG];

    always #4 clk = ~clk;

    seg_xlat #(.NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_seg(wr_seg),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_err(wr_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, sample just after the rising edge.
    task automatic cyc(input logic rv, input int seg, input int off,
                       input logic we, input logic wp, input int wseg,
                       input int wbase, input int wlim);
        @(negedge clk);
        req_valid = rv;
        req_seg   = SEG_W'(seg);
        req_off   = OFF_W'(off);
        wr_en     = we;
        wr_priv   = wp;
        wr_seg    = SEG_W'(wseg);
        wr_base   = PA_W'(wbase);
        wr_limit  = LIM_W'(wlim);
        @(posedge clk);
        #1;
    endtask

    task automatic req(input int seg, input int off);
        cyc(1'b1, seg, off, 1'b0, 1'b0, 0, 0, 0);
    endtask

    task automatic load(input int seg, input int base, input int lim);
        cyc(1'b0, 0, 0, 1'b1, 1'b1, seg, base, lim);
        exp_base[seg] = base;
        exp_lim[seg]  = lim;
    endtask

    task automatic expect_xlat(input string tag, input int seg, input int off);
        if (off < exp_lim[seg]) begin
            check({tag, " trap"}, int'(rsp_trap), 0);
            check({tag, " paddr"}, int'(rsp_paddr), (exp_base[seg] + off) % (1 << PA_W));
        end else begin
            check({tag, " trap"}, int'(rsp_trap), 1);
            check({tag, " paddr"}, int'(rsp_paddr), 0);
        end
        check({tag, " valid"}, int'(rsp_valid), 1);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_SEG; i++) begin
            exp_base[i] = 0;
            exp_lim[i]  = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        // R1: outputs quiet while in reset
        check("R1 valid in reset", int'(rsp_valid), 0);
        check("R1 trap in reset", int'(rsp_trap), 0);
        check("R1 err in reset", int'(wr_err), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table traps everywhere
        for (int s = 0; s < NUM_SEG; s++) begin
            req(s, 0);
            check("R1 empty entry traps", int'(rsp_trap), 1);
            req(s, (1 << OFF_W) - 1);
            check("R1 empty entry traps high", int'(rsp_trap), 1);
        end

        // R7: idle cycle gives no response
        cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0);
        check("R7 idle valid", int'(rsp_valid), 0);
        check("R7 idle trap", int'(rsp_trap), 0);

        // R5: load the table with a privileged writer
        load(0, 1400, 1000);
        load(1, 5017, 301);
        load(2, 4300, 400);
        load(3, 3200, 1100);
        load(4, 20017, 1201);
        load(5, 25017, 1);
        load(6, 30017, 1801);
        load(7, 63000, 1 << OFF_W);   // R8: full-range length, sum wraps
        check("R5 no err on priv write", int'(wr_err), 0);

        // R2 R3 R4: exhaustive sweep, each segment against its own entry
        for (int s = 0; s < NUM_SEG; s++) begin
            for (int o = 0; o < (1 << OFF_W); o++) begin
                req(s, o);
                expect_xlat("R4 sweep", s, o);
            end
        end

        // R2: in-range examples
        req(2, 53);
        check("R2 seg2 off53", int'(rsp_paddr), 4353);
        req(3, 852);
        check("R2 seg3 off852", int'(rsp_paddr), 4052);
        // R3: offset equal to length and beyond
        req(0, 1222);
        check("R3 seg0 off1222 trap", int'(rsp_trap), 1);
        req(2, 400);
        check("R3 seg2 off at length trap", int'(rsp_trap), 1);
        req(2, 399);
        check("R3 seg2 last byte ok", int'(rsp_trap), 0);
        // R8: top offset legal with full-range length
        req(7, (1 << OFF_W) - 1);
        check("R8 seg7 top offset trap", int'(rsp_trap), 0);
        check("R8 seg7 wrapped paddr", int'(rsp_paddr), (63000 + 4095) % 65536);

        // R6: unprivileged write rejected and flagged for one cycle
        cyc(1'b0, 0, 0, 1'b1, 1'b0, 2, 100, 5);
        check("R6 err pulse", int'(wr_err), 1);
        req(2, 53);
        check("R6 err clears", int'(wr_err), 0);
        check("R6 entry kept paddr", int'(rsp_paddr), 4353);
        req(2, 10);
        check("R6 entry kept trap", int'(rsp_trap), 0);

        // R5: same-cycle request sees old entry, next one sees the new one
        cyc(1'b1, 1, 0, 1'b1, 1'b1, 1, 777, 20);
        check("R5 same cycle old base", int'(rsp_paddr), 5017);
        exp_base[1] = 777;
        exp_lim[1]  = 20;
        req(1, 0);
        check("R5 new base", int'(rsp_paddr), 777);
        req(1, 20);
        check("R5 new length trap", int'(rsp_trap), 1);
        req(1, 19);
        expect_xlat("R5 new length last", 1, 19);

        // R7: request followed by idle drops valid
        cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0);
        check("R7 valid drops", int'(rsp_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule